// File: doc/BRIEF.md
# Audio Serial Clock Generator

This block produces the bit clock and the left/right frame clock for one audio serial port. Both clocks are derived from the master clock, which is the block's own clock. Two coded ratio fields set the timing. One gives the number of master clocks per frame. The other gives the number of bit clocks per frame, and the bit clock period follows from the quotient of the two. A format code picks I2S framing or left-justified framing. This fixes where the frame clock edge falls relative to the first data bit of each channel.

Each direction (transmit and receive) has its own master/slave selector:

- **Master direction:** it uses the internally generated clocks. The pins are driven while at least one direction is master.
- **Slave direction:** it takes its clocks from the pins.

Separate polarity bits invert the driven clocks in master mode and the received clocks in slave mode. The block-internal clocks handed to each direction always have true polarity: the bit clock falls where a bit is launched, and a low frame clock means the left channel.

A per-port enable gates everything. The ratio and format codes are captured only while the port is disabled, so the port must be configured before it is enabled. For each direction, a frame aligner emits a one-cycle strobe on the bit-clock fall at which the first bit of a channel is launched, together with a channel flag. Data shifting itself is left to the shifters that consume these strobes. There are no data streams at this block's edge, so no port uses a valid/ready handshake.

Top module: `audio_clkgen`

## Requirements
- R1: `mpf_code` sets the master clocks per frame: code 0 gives 512, 1 gives 256, 2 gives 128, 3 gives 64 and 4 gives 32. Codes 5 to 7 are invalid.
- R2: `bpf_code` sets the bit clocks per frame: code 0 gives 32, 1 gives 64, 2 gives 128, 3 gives 256, 4 gives 512 and 7 gives 16. Codes 5 and 6 are invalid.
- R3: In master mode, the internal bit clock has a period of (master clocks per frame ÷ bit clocks per frame) master clocks. It is low for the first half of each period. After the edge at which the enable is first sampled high, its value follows master clock count k = 0, 1, 2 …
- R4: `cfg_err` is high when either ratio code is invalid, when the ratio quotient is below 2, or when `fmt_code` is neither 2 nor 3. While it is high, the pins are not driven, the pin outputs are low and the internal clocks are low.
- R5: With `fmt_code` = 2 (left-justified), the frame clock is low for the first half of the frame and high for the second half. It changes on the same master clock as a bit-clock fall.
- R6: With `fmt_code` = 3 (I2S), the frame clock changes one bit-clock period earlier than in left-justified mode.
- R7: In master mode, `inv_m_lr` and `inv_m_bit` invert only the driven pin clocks. The internal clocks keep true polarity.
- R8: In slave mode, the internal clocks equal the pin inputs XOR `inv_s_bit` / `inv_s_lr`. The master inversion bits have no effect, and the pins are not driven when both directions are slaves.
- R9: `out_master` selects generated clocks for transmit and `in_master` does so for receive. `pin_drive_o` = enable AND NOT `cfg_err` AND (`out_master` OR `in_master`).
- R10: While `port_en` is low, the pin clocks and `pin_drive_o` are low at once. One edge later, the internal clocks, the counter and the strobes are cleared.
- R11: The ratio and format codes are sampled only on edges where `port_en` is low. Changes made while the port is enabled are ignored.
- R12: `*_chan_start` pulses for one cycle, one master clock after the internal bit-clock fall that launches a channel's first bit: in left-justified mode this is the fall at which the frame clock changed, in I2S mode the following fall. `*_chan_right` gives the frame-clock level at that fall, where 1 means the right channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_m | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| port_en | input | 1 | Port clock enable |
| mpf_code | input | 3 | Master-clocks-per-frame code |
| bpf_code | input | 3 | Bit-clocks-per-frame code |
| fmt_code | input | 3 | Framing code (2 left-justified, 3 I2S) |
| out_master | input | 1 | Transmit direction uses generated clocks |
| in_master | input | 1 | Receive direction uses generated clocks |
| inv_m_lr | input | 1 | Invert driven frame clock |
| inv_m_bit | input | 1 | Invert driven bit clock |
| inv_s_lr | input | 1 | Invert received frame clock |
| inv_s_bit | input | 1 | Invert received bit clock |
| bclk_pin_i | input | 1 | Bit clock from pin |
| lrck_pin_i | input | 1 | Frame clock from pin |
| bclk_pin_o | output | 1 | Bit clock to pin |
| lrck_pin_o | output | 1 | Frame clock to pin |
| pin_drive_o | output | 1 | Pin output enable |
| cfg_err | output | 1 | Captured configuration is invalid |
| tx_bclk | output | 1 | Transmit bit clock, true polarity |
| tx_lrck | output | 1 | Transmit frame clock, true polarity |
| tx_chan_start | output | 1 | Transmit channel-start strobe |
| tx_chan_right | output | 1 | Transmit channel flag |
| rx_bclk | output | 1 | Receive bit clock, true polarity |
| rx_lrck | output | 1 | Receive frame clock, true polarity |
| rx_chan_start | output | 1 | Receive channel-start strobe |
| rx_chan_right | output | 1 | Receive channel flag |

## Verification
The bench builds the block with its default 9-bit frame counter, so every legal code pair can be exercised. This covers the longest frame of 512 master clocks with a 32-clock bit period, down to the tightest legal case of a 32-clock frame with 16 bits, where the bit clock toggles on every master clock. At that width, the I2S look-ahead wrapping past the frame end and the quotient-of-one rejection are both within reach. The slave-side aligner is driven by hand-made pin waveforms to confirm that the same edge detection serves both modes.

// File: rtl/aclk_pkg.sv
package aclk_pkg;
  localparam int MAX_LOG2 = 9;
  localparam int LOG_W    = 4;

  localparam logic [2:0] FMT_LJ  = 3'd2;
  localparam logic [2:0] FMT_I2S = 3'd3;

  typedef struct packed {
    logic [LOG_W-1:0] frame_log2;
    logic [LOG_W-1:0] div_log2;
    logic             i2s;
    logic             err;
  } aclk_cfg_t;

  // master clocks per frame, as log2; 0 marks an illegal code
  function automatic logic [LOG_W-1:0] frame_log2_of(input logic [2:0] code);
    case (code)
      3'd0:    return LOG_W'(9);
      3'd1:    return LOG_W'(8);
      3'd2:    return LOG_W'(7);
      3'd3:    return LOG_W'(6);
      3'd4:    return LOG_W'(5);
      default: return '0;
    endcase
  endfunction

  // bit clocks per frame, as log2; 0 marks an illegal code
  function automatic logic [LOG_W-1:0] bits_log2_of(input logic [2:0] code);
    case (code)
      3'd7:    return LOG_W'(4);
      3'd0:    return LOG_W'(5);
      3'd1:    return LOG_W'(6);
      3'd2:    return LOG_W'(7);
      3'd3:    return LOG_W'(8);
      3'd4:    return LOG_W'(9);
      default: return '0;
    endcase
  endfunction
endpackage

// File: rtl/aclk_cfg_shadow.sv
module aclk_cfg_shadow
  import aclk_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      port_en,
  input  logic [2:0] mpf_code,
  input  logic [2:0] bpf_code,
  input  logic [2:0] fmt_code,
  output aclk_cfg_t cfg
);
  logic [2:0] mpf_q, bpf_q, fmt_q;
  logic [LOG_W-1:0] fl, bl;
  logic fmt_ok;

  // codes are only taken while the port is idle (R11)
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mpf_q <= '0;
      bpf_q <= '0;
      fmt_q <= '0;
    end else if (!port_en) begin
      mpf_q <= mpf_code;
      bpf_q <= bpf_code;
      fmt_q <= fmt_code;
    end
  end

  always_comb begin
    fl             = frame_log2_of(mpf_q);
    bl             = bits_log2_of(bpf_q);
    fmt_ok         = (fmt_q == FMT_LJ) || (fmt_q == FMT_I2S);
    cfg.frame_log2 = fl;
    cfg.div_log2   = fl - bl;
    cfg.i2s        = (fmt_q == FMT_I2S);
    cfg.err        = (fl == '0) || (bl == '0) || (fl <= bl) || !fmt_ok;
  end
endmodule

// File: rtl/aclk_master_gen.sv
module aclk_master_gen #(
  parameter int CNT_W = aclk_pkg::MAX_LOG2,
  parameter int LOG_W = aclk_pkg::LOG_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [LOG_W-1:0] frame_log2,
  input  logic [LOG_W-1:0] div_log2,
  input  logic             i2s,
  output logic             bclk_g,
  output logic             lrck_g
);
  logic [CNT_W-1:0] cnt, mask, step, ahead, cnt_nxt, bsh, lsh;
  logic [LOG_W-1:0] bidx, fidx;

  always_comb begin
    mask    = (CNT_W'(1) << frame_log2) - CNT_W'(1);
    step    = CNT_W'(1) << div_log2;
    ahead   = (cnt + step) & mask;
    cnt_nxt = (cnt + CNT_W'(1)) & mask;
    bidx    = div_log2 - LOG_W'(1);
    fidx    = frame_log2 - LOG_W'(1);
    bsh     = cnt >> bidx;
    // I2S looks one bit period ahead so the frame edge leads the data
    lsh     = (i2s ? ahead : cnt) >> fidx;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt    <= '0;
      bclk_g <= 1'b0;
      lrck_g <= 1'b0;
    end else if (!run) begin
      cnt    <= '0;
      bclk_g <= 1'b0;
      lrck_g <= 1'b0;
    end else begin
      cnt    <= cnt_nxt;
      bclk_g <= bsh[0];
      lrck_g <= lsh[0];
    end
  end
endmodule

// File: rtl/aclk_frame_align.sv
module aclk_frame_align (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic i2s,
  input  logic bclk_i,
  input  logic lrck_i,
  output logic chan_start,
  output logic chan_right
);
  logic bclk_q, lr_prev, pend;
  logic fall, changed;

  assign fall    = bclk_q & ~bclk_i;
  assign changed = lrck_i ^ lr_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bclk_q     <= 1'b0;
      lr_prev    <= 1'b0;
      pend       <= 1'b0;
      chan_start <= 1'b0;
      chan_right <= 1'b0;
    end else if (!run) begin
      bclk_q     <= 1'b0;
      lr_prev    <= 1'b0;
      pend       <= 1'b0;
      chan_start <= 1'b0;
      chan_right <= 1'b0;
    end else begin
      bclk_q     <= bclk_i;
      chan_start <= fall & (i2s ? pend : changed);
      if (fall) begin
        lr_prev    <= lrck_i;
        pend       <= changed;
        chan_right <= lrck_i;
      end
    end
  end
endmodule

// File: rtl/audio_clkgen.sv
module audio_clkgen
  import aclk_pkg::*;
#(
  parameter int CNT_W = MAX_LOG2
) (
  input  logic       clk_m,
  input  logic       rst_n,
  input  logic       port_en,
  input  logic [2:0] mpf_code,
  input  logic [2:0] bpf_code,
  input  logic [2:0] fmt_code,
  input  logic       out_master,
  input  logic       in_master,
  input  logic       inv_m_lr,
  input  logic       inv_m_bit,
  input  logic       inv_s_lr,
  input  logic       inv_s_bit,
  input  logic       bclk_pin_i,
  input  logic       lrck_pin_i,
  output logic       bclk_pin_o,
  output logic       lrck_pin_o,
  output logic       pin_drive_o,
  output logic       cfg_err,
  output logic       tx_bclk,
  output logic       tx_lrck,
  output logic       tx_chan_start,
  output logic       tx_chan_right,
  output logic       rx_bclk,
  output logic       rx_lrck,
  output logic       rx_chan_start,
  output logic       rx_chan_right
);
  localparam int NDIR = 2;

  aclk_cfg_t cfg;
  logic run, gen_bclk, gen_lrck, slv_bclk, slv_lrck;
  logic [NDIR-1:0] dir_master, dir_bclk, dir_lrck, dir_start, dir_right;

  aclk_cfg_shadow u_cfg (
    .clk      (clk_m),
    .rst_n    (rst_n),
    .port_en  (port_en),
    .mpf_code (mpf_code),
    .bpf_code (bpf_code),
    .fmt_code (fmt_code),
    .cfg      (cfg)
  );

  assign run     = port_en & ~cfg.err;
  assign cfg_err = cfg.err;

  aclk_master_gen #(.CNT_W(CNT_W), .LOG_W(LOG_W)) u_gen (
    .clk        (clk_m),
    .rst_n      (rst_n),
    .run        (run),
    .frame_log2 (cfg.frame_log2),
    .div_log2   (cfg.div_log2),
    .i2s        (cfg.i2s),
    .bclk_g     (gen_bclk),
    .lrck_g     (gen_lrck)
  );

  // pins in slave mode, restored to true polarity
  assign slv_bclk = run & (bclk_pin_i ^ inv_s_bit);
  assign slv_lrck = run & (lrck_pin_i ^ inv_s_lr);

  // pin side: driven when any direction is master
  assign pin_drive_o = run & (out_master | in_master);
  assign bclk_pin_o  = pin_drive_o & (gen_bclk ^ inv_m_bit);
  assign lrck_pin_o  = pin_drive_o & (gen_lrck ^ inv_m_lr);

  assign dir_master = {in_master, out_master};

  for (genvar g = 0; g < NDIR; g++) begin : g_dir
    assign dir_bclk[g] = dir_master[g] ? gen_bclk : slv_bclk;
    assign dir_lrck[g] = dir_master[g] ? gen_lrck : slv_lrck;

    aclk_frame_align u_align (
      .clk        (clk_m),
      .rst_n      (rst_n),
      .run        (run),
      .i2s        (cfg.i2s),
      .bclk_i     (dir_bclk[g]),
      .lrck_i     (dir_lrck[g]),
      .chan_start (dir_start[g]),
      .chan_right (dir_right[g])
    );
  end

  assign tx_bclk       = dir_bclk[0];
  assign tx_lrck       = dir_lrck[0];
  assign tx_chan_start = dir_start[0];
  assign tx_chan_right = dir_right[0];
  assign rx_bclk       = dir_bclk[1];
  assign rx_lrck       = dir_lrck[1];
  assign rx_chan_start = dir_start[1];
  assign rx_chan_right = dir_right[1];
endmodule

// File: rtl/audio_clkgen_chk.sv
module audio_clkgen_chk (
  input logic clk_m,
  input logic rst_n,
  input logic port_en,
  input logic out_master,
  input logic in_master,
  input logic cfg_err,
  input logic pin_drive_o,
  input logic bclk_pin_o,
  input logic lrck_pin_o,
  input logic tx_bclk,
  input logic tx_lrck,
  input logic tx_chan_start
);
  p_idle_low_r10: assert property (@(posedge clk_m) disable iff (!rst_n)
    !port_en |-> (!bclk_pin_o && !lrck_pin_o && !pin_drive_o));

  p_idle_nostart_r10: assert property (@(posedge clk_m) disable iff (!rst_n)
    (!port_en && !$past(port_en)) |-> !tx_chan_start);

  p_err_no_drive_r4: assert property (@(posedge clk_m) disable iff (!rst_n)
    cfg_err |-> !pin_drive_o);

  p_slave_nodrive_r8: assert property (@(posedge clk_m) disable iff (!rst_n)
    (!out_master && !in_master) |-> !pin_drive_o);

  p_start_single_r12: assert property (@(posedge clk_m) disable iff (!rst_n)
    tx_chan_start |=> !tx_chan_start);

  p_cfg_frozen_r11: assert property (@(posedge clk_m) disable iff (!rst_n)
    (port_en && $past(port_en)) |-> $stable(cfg_err));

  p_lr_on_fall_r5: assert property (@(posedge clk_m) disable iff (!rst_n)
    (out_master && $past(out_master) && port_en && $past(port_en) && !cfg_err
     && (tx_lrck != $past(tx_lrck))) |-> (!tx_bclk && $past(tx_bclk)));
endmodule

bind audio_clkgen audio_clkgen_chk chk_i (
  .clk_m         (clk_m),
  .rst_n         (rst_n),
  .port_en       (port_en),
  .out_master    (out_master),
  .in_master     (in_master),
  .cfg_err       (cfg_err),
  .pin_drive_o   (pin_drive_o),
  .bclk_pin_o    (bclk_pin_o),
  .lrck_pin_o    (lrck_pin_o),
  .tx_bclk       (tx_bclk),
  .tx_lrck       (tx_lrck),
  .tx_chan_start (tx_chan_start)
);

// File: tb/audio_clkgen_tb_top.sv
module audio_clkgen_tb_top;
  logic clk_m = 1'b0;
  logic rst_n = 1'b0;
  logic port_en = 1'b0;
  logic [2:0] mpf_code = 3'd4, bpf_code = 3'd7, fmt_code = 3'd2;
  logic out_master = 1'b1, in_master = 1'b1;
  logic inv_m_lr = 1'b0, inv_m_bit = 1'b0, inv_s_lr = 1'b0, inv_s_bit = 1'b0;
  logic bclk_pin_i = 1'b0, lrck_pin_i = 1'b0;
  logic bclk_pin_o, lrck_pin_o, pin_drive_o, cfg_err;
  logic tx_bclk, tx_lrck, tx_chan_start, tx_chan_right;
  logic rx_bclk, rx_lrck, rx_chan_start, rx_chan_right;

  int checks = 0;
  int errors = 0;

  always #10 clk_m = ~clk_m;

  audio_clkgen dut_i (.*);

  // {mpf, bpf, fmt, inv_lr, inv_bit, err, frame_log2, bits_log2}
  localparam int NV = 10;
  localparam logic [19:0] VEC [NV] = '{
    {3'd4, 3'd7, 3'd2, 1'b0, 1'b0, 1'b0, 4'd5, 4'd4},
    {3'd3, 3'd0, 3'd3, 1'b0, 1'b0, 1'b0, 4'd6, 4'd5},
    {3'd0, 3'd7, 3'd3, 1'b1, 1'b0, 1'b0, 4'd9, 4'd4},
    {3'd1, 3'd1, 3'd2, 1'b0, 1'b1, 1'b0, 4'd8, 4'd6},
    {3'd2, 3'd0, 3'd3, 1'b1, 1'b1, 1'b0, 4'd7, 4'd5},
    {3'd4, 3'd0, 3'd2, 1'b0, 1'b0, 1'b1, 4'd0, 4'd0},
    {3'd5, 3'd0, 3'd2, 1'b0, 1'b0, 1'b1, 4'd0, 4'd0},
    {3'd1, 3'd5, 3'd2, 1'b0, 1'b0, 1'b1, 4'd0, 4'd0},
    {3'd1, 3'd1, 3'd1, 1'b0, 1'b0, 1'b1, 4'd0, 4'd0},
    {3'd0, 3'd4, 3'd3, 1'b0, 1'b0, 1'b1, 4'd0, 4'd0}
  };

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  task automatic tick(input int n);
    repeat (n) begin
      @(posedge clk_m);
      @(negedge clk_m);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk_m);
    errors++;
    $display("FAIL watchdog: actual 1 expected 0");
    finish_run();
  end

  initial begin
    int starts;
    logic prev_b;
    repeat (3) @(negedge clk_m);
    rst_n = 1'b1;
    tick(2);
    // reset / idle state (R10)
    check("R10 reset drive", int'(pin_drive_o), 0);
    check("R10 reset bclk pin", int'(bclk_pin_o), 0);
    check("R10 reset tx bclk", int'(tx_bclk), 0);
    check("R10 reset start", int'(tx_chan_start), 0);

    // table of configurations, both directions master
    for (int i = 0; i < NV; i++) begin
      logic [19:0] v;
      int m, b, d, mpf, bpf, ilr, ibit;
      bit i2s;
      string etag;
      v = VEC[i];
      port_en  = 1'b0;
      mpf_code = v[19:17];
      bpf_code = v[16:14];
      fmt_code = v[13:11];
      inv_m_lr = v[10];
      inv_m_bit = v[9];
      ilr = int'(v[10]);
      ibit = int'(v[9]);
      m = int'(v[7:4]);
      b = int'(v[3:0]);
      i2s = (v[13:11] == 3'd3);
      etag = (i == 6) ? "R1 bad code" : (i == 7) ? "R2 bad code" : "R4 cfg_err";
      tick(2);
      port_en = 1'b1;
      if (v[8]) begin
        for (int k = 0; k < 6; k++) begin
          tick(1);
          check(etag, int'(cfg_err), 1);
          check("R4 no drive", int'(pin_drive_o), 0);
          check("R4 pin bclk low", int'(bclk_pin_o), 0);
          check("R4 tx bclk low", int'(tx_bclk), 0);
          check("R4 tx lrck low", int'(tx_lrck), 0);
        end
      end else begin
        d = m - b;
        mpf = 1 << m;
        bpf = 1 << b;
        for (int k = 0; k < 2 * mpf + 4; k++) begin
          int km, j, s, eb, el, es, er;
          @(posedge clk_m);
          @(negedge clk_m);
          km = k % mpf;
          eb = (km >> (d - 1)) & 1;
          el = i2s ? ((((k + (1 << d)) % mpf) >> (m - 1)) & 1) : ((km >> (m - 1)) & 1);
          j  = k - 1;
          s  = (j >= 0) ? ((j % mpf) >> d) : 0;
          es = (j > 0 && (j % (1 << d)) == 0 && (s == 0 || s == bpf / 2)) ? 1 : 0;
          er = (s >= bpf / 2) ? 1 : 0;
          if (k == 0) begin
            check("R1 R2 cfg valid", int'(cfg_err), 0);
            check("R9 drive", int'(pin_drive_o), 1);
          end
          check("R3 tx bclk", int'(tx_bclk), eb);
          check(i2s ? "R6 tx lrck i2s" : "R5 tx lrck lj", int'(tx_lrck), el);
          check("R7 pin bclk", int'(bclk_pin_o), eb ^ ibit);
          check("R7 pin lrck", int'(lrck_pin_o), el ^ ilr);
          check("R9 rx bclk", int'(rx_bclk), eb);
          check("R12 tx start", int'(tx_chan_start), es);
          check("R12 rx start", int'(rx_chan_start), es);
          if (es == 1) check("R12 right flag", int'(tx_chan_right), er);
        end
      end
    end

    // R10: disable in the middle of a run
    port_en = 1'b0;
    inv_m_lr = 1'b1;
    inv_m_bit = 1'b1;
    mpf_code = 3'd3; bpf_code = 3'd0; fmt_code = 3'd2;
    tick(2);
    port_en = 1'b1;
    tick(5);
    port_en = 1'b0;
    #1;
    check("R10 pin bclk off now", int'(bclk_pin_o), 0);
    check("R10 pin lrck off now", int'(lrck_pin_o), 0);
    check("R10 drive off now", int'(pin_drive_o), 0);
    tick(1);
    check("R10 tx bclk cleared", int'(tx_bclk), 0);
    check("R10 tx lrck cleared", int'(tx_lrck), 0);
    check("R10 start cleared", int'(tx_chan_start), 0);

    // R11: codes changed while enabled are ignored
    inv_m_lr = 1'b0;
    inv_m_bit = 1'b0;
    mpf_code = 3'd4; bpf_code = 3'd7; fmt_code = 3'd2;
    tick(2);
    port_en = 1'b1;
    tick(1);
    bpf_code = 3'd5;
    fmt_code = 3'd0;
    prev_b = tx_bclk;
    for (int k = 0; k < 6; k++) begin
      tick(1);
      check("R11 cfg frozen", int'(cfg_err), 0);
      check("R11 bclk keeps toggling", int'(tx_bclk), int'(!prev_b));
      prev_b = tx_bclk;
    end
    port_en = 1'b0;
    tick(2);
    check("R11 new code taken when idle", int'(cfg_err), 1);

    // R9: transmit master, receive slave
    mpf_code = 3'd4; bpf_code = 3'd7; fmt_code = 3'd2;
    out_master = 1'b1; in_master = 1'b0;
    tick(2);
    port_en = 1'b1;
    bclk_pin_i = 1'b1;
    inv_s_bit = 1'b0;
    tick(1);
    check("R9 mixed drive", int'(pin_drive_o), 1);
    check("R9 rx from pin", int'(rx_bclk), 1);
    inv_s_bit = 1'b1;
    #1;
    check("R9 rx from pin inverted", int'(rx_bclk), 0);

    // R8: both slave, master inversion ignored
    port_en = 1'b0;
    out_master = 1'b0;
    inv_m_bit = 1'b1;
    inv_m_lr = 1'b1;
    tick(2);
    port_en = 1'b1;
    bclk_pin_i = 1'b0;
    lrck_pin_i = 1'b1;
    inv_s_bit = 1'b1;
    inv_s_lr = 1'b0;
    tick(1);
    check("R8 no drive", int'(pin_drive_o), 0);
    check("R8 pin bclk low", int'(bclk_pin_o), 0);
    check("R8 pin lrck low", int'(lrck_pin_o), 0);
    check("R8 tx bclk from pin", int'(tx_bclk), 1);
    check("R8 tx lrck from pin", int'(tx_lrck), 1);

    // R8 / R12: slave framing, left-justified, hand-made pin clocks
    port_en = 1'b0;
    inv_s_bit = 1'b0;
    bclk_pin_i = 1'b0;
    lrck_pin_i = 1'b0;
    tick(2);
    port_en = 1'b1;
    starts = 0;
    for (int f = 0; f < 2; f++) begin
      for (int s = 0; s < 8; s++) begin
        lrck_pin_i = (s >= 4);
        bclk_pin_i = 1'b0;
        for (int c = 0; c < 2; c++) begin
          tick(1);
          if (tx_chan_start) starts++;
        end
        bclk_pin_i = 1'b1;
        for (int c = 0; c < 2; c++) begin
          tick(1);
          if (tx_chan_start) starts++;
        end
      end
    end
    check("R12 slave start count", starts, 3);
    check("R12 slave last flag right", int'(tx_chan_right), 1);
    port_en = 1'b0;
    tick(2);
    finish_run();
  end
endmodule